// File: doc/BRIEF.md
# Clock Mode and Standby Controller

This controller picks the run clock for a small microcontroller and sequences its low-power states. Three run sources exist: the oscillator clock divided by two, a PLL clock, and a slow clock divided by two or by four. The slow clock can come from an external pin or from an internal RC oscillator. The block runs on the oscillator clock. It sees each slow-clock edge as a one-cycle tick input, and it produces clock enables, not clocks. The enables are for the CPU and for the peripherals. The block also drives the select code for an external glitch-free clock mux, and enables for the main oscillator, the PLL, the watch timer and the low-voltage detector.

Software writes a target run mode and a standby request (sleep, watch or stop). A wake event, when enabled, brings the block back to the run mode it left. A settle counter counts slow-clock ticks after reset and after every stop. A switch to the slow clock waits until that counter has finished. A switch to the PLL first turns the PLL on, then waits for the lock input. A CPU intermittent option passes CPU clock enables only during CPU accesses.

Top module: `clkmode_standby_ctrl`

## Requirements
- R1: Once reset has been released, the state status is 0 (run), the mode status is 0 (main), `osc_en` is 1, `pll_en` is 0 and `settled` is 0.
- R2: In main mode (mode code 0) in run, `per_clk_en` and `cpu_clk_en` are high on exactly half of the clock cycles, and never on two cycles in a row.
- R3: A write of mode code 1 (PLL) raises `pll_en` after one cycle. The mode status moves to 1 only on the edge after one at which `pll_locked` was seen with `pll_en` high. From then on, the enables are high every cycle.
- R4: A write of mode code 2 (sub-clock) takes effect one edge after `settled` is high, and not before. In that mode `osc_en` and `pll_en` are low. The peripheral enable pulses once for every 2 selected slow ticks when `sub_div4` is 0, and once for every 4 when it is 1. The slow ticks come from `slow_int_tick` when `slow_src_int` is 1 and from `slow_ext_tick` when it is 0.
- R5: `settled` rises after 2^SETTLE_W selected slow ticks, counted from reset or from the edge that leaves stop. It returns to 0 one cycle after stop is entered.
- R6: Standby code 1 (sleep, state status 1) holds `cpu_clk_en` low. The peripheral enable keeps the rate of the run mode in force before entry.
- R7: Standby code 2 (watch, state status 2) drives the CPU enable, the peripheral enable, `osc_en` and `pll_en` low, and holds `watch_tmr_en` and `lvd_en` high.
- R8: Standby code 3 (stop, state status 3) drives every enable output low, `watch_tmr_en` and `lvd_en` included.
- R9: `wake_evt` with `wake_en` high returns the block from sleep, watch or stop to run, with an unchanged mode status. The state status and the clock enables resume on the same cycle. `wake_evt` with `wake_en` low has no effect.
- R10: With `intermittent` high in run, `cpu_clk_en` is high only on run-clock cycles where `cpu_access` is high. `per_clk_en` is not affected.
- R11: If a standby request and a mode write arrive in the same cycle, the standby request is taken and the mode write is dropped. Mode and standby writes made outside run are ignored.
- R12: A mode write of code 3 and a standby write of code 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_ext_tick | input | 1 | One-cycle pulse per edge of the external slow clock |
| slow_int_tick | input | 1 | One-cycle pulse per edge of the internal RC slow clock |
| slow_src_int | input | 1 | 1 selects the internal slow source |
| sub_div4 | input | 1 | 1 divides the slow clock by 4, 0 by 2 |
| pll_locked | input | 1 | PLL lock indication |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel | input | 2 | Requested run mode (0 main, 1 PLL, 2 sub-clock) |
| stby_wr | input | 1 | Standby write strobe |
| stby_sel | input | 2 | Standby request (0 none, 1 sleep, 2 watch, 3 stop) |
| wake_evt | input | 1 | Wake event |
| wake_en | input | 1 | Wake enable |
| intermittent | input | 1 | CPU intermittent operation |
| cpu_access | input | 1 | CPU is performing an access |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| clk_src_sel | output | 2 | Source select code for the external clock mux |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| watch_tmr_en | output | 1 | Watch timer enable |
| lvd_en | output | 1 | Low-voltage detector enable |
| settled | output | 1 | Slow clock settle wait complete |
| stat_mode | output | 2 | Active run mode |
| stat_state | output | 2 | Active state (0 run, 1 sleep, 2 watch, 3 stop) |

## Verification
The assertions assume three things about the inputs. Each slow tick input is a single-cycle pulse, synchronous to `clk`. `pll_locked` is only used after the controller has raised `pll_en`. Wake events are meaningful only outside run. The stimulus makes both slow tick streams strictly periodic (every second and every third cycle). It raises `pll_locked` only after it has seen `pll_en` high, and it changes each request strobe for one cycle at a time. The tick counts that are compared are taken over windows that span whole divider periods, so the divider phase does not change the expected count.

// File: rtl/ckm_pkg.sv
package ckm_pkg;
  typedef enum logic [1:0] {
    MODE_MAIN = 2'd0,
    MODE_PLL  = 2'd1,
    MODE_SUB  = 2'd2,
    MODE_RSVD = 2'd3
  } ckm_mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WATCH = 2'd2,
    ST_STOP  = 2'd3
  } ckm_state_e;

  localparam logic [1:0] REQ_NONE  = 2'd0;
  localparam logic [1:0] REQ_SLEEP = 2'd1;
  localparam logic [1:0] REQ_WATCH = 2'd2;
  localparam logic [1:0] REQ_STOP  = 2'd3;
endpackage

// File: rtl/ckm_tick_gen.sv
module ckm_tick_gen #(
  parameter int SUB_CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_tick,
  input  logic int_tick,
  input  logic src_int,
  input  logic div4,
  input  logic osc_run,
  output logic slow_tick,
  output logic main_pulse,
  output logic sub_pulse
);
  localparam logic [SUB_CNT_W-1:0] CNT_LAST = '1;

  logic                 div_q, div_d;
  logic [SUB_CNT_W-1:0] cnt_q, cnt_d;
  logic                 pulse_q, pulse_d;

  // slow source select and dividers, next state
  always_comb begin
    slow_tick = src_int ? int_tick : ext_tick;
    div_d     = osc_run ? ~div_q : 1'b0;
    cnt_d     = slow_tick ? cnt_q + 1'b1 : cnt_q;
    pulse_d   = slow_tick & (div4 ? (cnt_q == CNT_LAST) : cnt_q[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      div_q   <= div_d;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign main_pulse = div_q;
  assign sub_pulse  = pulse_q;

  AST_MAIN_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    main_pulse |=> !main_pulse); // R2
  AST_SUB_PULSE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sub_pulse |-> $past(slow_tick)); // R4
endmodule

// File: rtl/ckm_settle.sv
module ckm_settle #(
  parameter int W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic settled
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (clr) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (tick && !done_q) begin
      if (cnt_q == CNT_MAX) begin
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign settled = done_q;

  AST_SETTLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !settled); // R5
  AST_SETTLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> $past(tick)); // R5
endmodule

// File: rtl/ckm_mode_fsm.sv
module ckm_mode_fsm
  import ckm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_sel,
  input  logic       stby_wr,
  input  logic [1:0] stby_sel,
  input  logic       wake_evt,
  input  logic       wake_en,
  input  logic       pll_locked,
  input  logic       settled,
  output ckm_state_e state_q,
  output ckm_mode_e  cur_q,
  output logic       pll_en_q,
  output logic       osc_en
);
  ckm_state_e state_d;
  ckm_mode_e  cur_d, tgt_q, tgt_d;
  logic       pll_en_d;
  logic       run_like_d;

  // state and target selection
  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    if (state_q == ST_RUN) begin
      if (stby_wr && stby_sel != REQ_NONE) begin
        state_d = ckm_state_e'(stby_sel);
      end else if (mode_wr && mode_sel != MODE_RSVD) begin
        tgt_d = ckm_mode_e'(mode_sel);
      end
    end else if (wake_evt && wake_en) begin
      state_d = ST_RUN;
    end
  end

  // active source switch, only while staying in run
  always_comb begin
    cur_d = cur_q;
    if (state_q == ST_RUN && state_d == ST_RUN) begin
      case (tgt_d)
        MODE_MAIN: cur_d = MODE_MAIN;
        MODE_PLL:  if (pll_en_q && pll_locked) cur_d = MODE_PLL;
        MODE_SUB:  if (settled) cur_d = MODE_SUB;
        default:   cur_d = cur_q;
      endcase
    end
  end

  always_comb begin
    run_like_d = (state_d == ST_RUN) || (state_d == ST_SLEEP);
    pll_en_d   = run_like_d && (tgt_d == MODE_PLL || cur_d == MODE_PLL);
    osc_en     = ((state_q == ST_RUN) || (state_q == ST_SLEEP)) &&
                 !(cur_q == MODE_SUB && tgt_q == MODE_SUB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      cur_q    <= MODE_MAIN;
      tgt_q    <= MODE_MAIN;
      pll_en_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cur_q    <= cur_d;
      tgt_q    <= tgt_d;
      pll_en_q <= pll_en_d;
    end
  end

  AST_SUB_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == MODE_SUB && $past(cur_q) != MODE_SUB) |-> $past(settled)); // R4
  AST_PLL_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == MODE_PLL && $past(cur_q) != MODE_PLL) |-> $past(pll_locked && pll_en_q)); // R3
  AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) != ST_RUN && state_q == ST_RUN) |-> $past(wake_evt && wake_en)); // R9
  AST_MODE_HELD_IN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) != ST_RUN) |-> $stable(cur_q)); // R11
endmodule

// File: rtl/clkmode_standby_ctrl.sv
module clkmode_standby_ctrl
  import ckm_pkg::*;
#(
  parameter int SETTLE_W  = 14,
  parameter int SUB_CNT_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_ext_tick,
  input  logic       slow_int_tick,
  input  logic       slow_src_int,
  input  logic       sub_div4,
  input  logic       pll_locked,
  input  logic       mode_wr,
  input  logic [1:0] mode_sel,
  input  logic       stby_wr,
  input  logic [1:0] stby_sel,
  input  logic       wake_evt,
  input  logic       wake_en,
  input  logic       intermittent,
  input  logic       cpu_access,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic [1:0] clk_src_sel,
  output logic       osc_en,
  output logic       pll_en,
  output logic       watch_tmr_en,
  output logic       lvd_en,
  output logic       settled,
  output logic [1:0] stat_mode,
  output logic [1:0] stat_state
);
  logic       rst_s0_q, rst_s1_q, rst_s;
  logic       slow_tick, main_pulse, sub_pulse;
  logic       run_tick, settle_clr, settle_done;
  logic       osc_en_i, pll_en_i;
  ckm_state_e state_q;
  ckm_mode_e  cur_q;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0_q <= 1'b0;
      rst_s1_q <= 1'b0;
    end else begin
      rst_s0_q <= 1'b1;
      rst_s1_q <= rst_s0_q;
    end
  end
  assign rst_s = rst_s1_q;

  ckm_tick_gen #(.SUB_CNT_W(SUB_CNT_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_s),
    .ext_tick  (slow_ext_tick),
    .int_tick  (slow_int_tick),
    .src_int   (slow_src_int),
    .div4      (sub_div4),
    .osc_run   (osc_en_i),
    .slow_tick (slow_tick),
    .main_pulse(main_pulse),
    .sub_pulse (sub_pulse)
  );

  assign settle_clr = (state_q == ST_STOP);

  ckm_settle #(.W(SETTLE_W)) u_settle (
    .clk    (clk),
    .rst_n  (rst_s),
    .clr    (settle_clr),
    .tick   (slow_tick),
    .settled(settle_done)
  );

  ckm_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_s),
    .mode_wr   (mode_wr),
    .mode_sel  (mode_sel),
    .stby_wr   (stby_wr),
    .stby_sel  (stby_sel),
    .wake_evt  (wake_evt),
    .wake_en   (wake_en),
    .pll_locked(pll_locked),
    .settled   (settle_done),
    .state_q   (state_q),
    .cur_q     (cur_q),
    .pll_en_q  (pll_en_i),
    .osc_en    (osc_en_i)
  );

  // run clock enable from the active source
  always_comb begin
    case (cur_q)
      MODE_MAIN: run_tick = main_pulse;
      MODE_PLL:  run_tick = 1'b1;
      MODE_SUB:  run_tick = sub_pulse;
      default:   run_tick = 1'b0;
    endcase
  end

  // gating per state
  always_comb begin
    cpu_clk_en   = (state_q == ST_RUN) && run_tick && (!intermittent || cpu_access);
    per_clk_en   = ((state_q == ST_RUN) || (state_q == ST_SLEEP)) && run_tick;
    watch_tmr_en = (state_q != ST_STOP);
    lvd_en       = (state_q != ST_STOP);
  end

  assign clk_src_sel = cur_q;
  assign osc_en      = osc_en_i;
  assign pll_en      = pll_en_i;
  assign settled     = settle_done;
  assign stat_mode   = cur_q;
  assign stat_state  = state_q;

  AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_s)
    (stat_state == ST_STOP) |-> !(osc_en || pll_en || per_clk_en || watch_tmr_en)); // R8
  AST_WATCH_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_s)
    (stat_state == ST_WATCH) |-> !(osc_en || pll_en || per_clk_en)); // R7
  AST_SUB_PLL_OFF: assert property (@(posedge clk) disable iff (!rst_s)
    (stat_mode == MODE_SUB && $past(stat_mode) == MODE_SUB) |-> !pll_en); // R4
  AST_CPU_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_s)
    cpu_clk_en |-> (stat_state == ST_RUN)); // R6
endmodule

// File: tb/clkmode_standby_ctrl_bench.sv
module clkmode_standby_ctrl_bench;
  localparam int SW = 4;
  localparam int SETTLE_TICKS = 1 << SW;

  logic       clk, rst_n;
  logic       slow_ext_tick, slow_int_tick, slow_src_int, sub_div4, pll_locked;
  logic       mode_wr, stby_wr, wake_evt, wake_en, intermittent, cpu_access;
  logic [1:0] mode_sel, stby_sel;
  logic       cpu_clk_en, per_clk_en, osc_en, pll_en, watch_tmr_en, lvd_en, settled;
  logic [1:0] clk_src_sel, stat_mode, stat_state;

  int checks, fails, stepno, seen;
  bit gen_on, m_stop, done;

  clkmode_standby_ctrl #(.SETTLE_W(SW)) u_clkmode_standby_ctrl (
    .clk(clk), .rst_n(rst_n),
    .slow_ext_tick(slow_ext_tick), .slow_int_tick(slow_int_tick),
    .slow_src_int(slow_src_int), .sub_div4(sub_div4), .pll_locked(pll_locked),
    .mode_wr(mode_wr), .mode_sel(mode_sel), .stby_wr(stby_wr), .stby_sel(stby_sel),
    .wake_evt(wake_evt), .wake_en(wake_en), .intermittent(intermittent),
    .cpu_access(cpu_access), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .clk_src_sel(clk_src_sel), .osc_en(osc_en), .pll_en(pll_en),
    .watch_tmr_en(watch_tmr_en), .lvd_en(lvd_en), .settled(settled),
    .stat_mode(stat_mode), .stat_state(stat_state)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive the slow ticks, model the settle count, sample after the edge
  task automatic step();
    slow_ext_tick = gen_on && (stepno % 2 == 0);
    slow_int_tick = gen_on && (stepno % 3 == 0);
    if (m_stop) seen = 0;
    else if (slow_src_int ? slow_int_tick : slow_ext_tick) seen++;
    @(posedge clk);
    #2;
    stepno++;
  endtask

  task automatic write_mode(input logic [1:0] m);
    mode_wr = 1'b1; mode_sel = m; step(); mode_wr = 1'b0;
  endtask

  task automatic write_stby(input logic [1:0] s);
    stby_wr = 1'b1; stby_sel = s; step(); stby_wr = 1'b0;
  endtask

  task automatic wake(input logic en);
    wake_evt = 1'b1; wake_en = en; step(); wake_evt = 1'b0; wake_en = 1'b0;
  endtask

  task automatic count_en(input int n, output int per_n, output int cpu_n);
    per_n = 0; cpu_n = 0;
    for (int i = 0; i < n; i++) begin
      step();
      per_n += int'(per_clk_en);
      cpu_n += int'(cpu_clk_en);
    end
  endtask

  // request the slow clock and follow the settle wait until the switch
  task automatic settle_and_switch(input string tag);
    bit prev;
    write_mode(2'd2);
    chk({tag, " mode held while unsettled"}, stat_mode, 0);
    for (int i = 0; i < 3 * SETTLE_TICKS; i++) begin
      prev = (seen >= SETTLE_TICKS);
      step();
      chk({tag, " settled flag"}, settled, int'(seen >= SETTLE_TICKS));
      chk({tag, " mode follows settle"}, stat_mode, prev ? 2 : 0);
      chk({tag, " osc_en"}, osc_en, prev ? 0 : 1);
    end
  endtask

  initial begin
    done = 1'b0;
    #3_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int pn, cn;
    checks = 0; fails = 0; stepno = 0; seen = 0; gen_on = 0; m_stop = 0;
    rst_n = 0; slow_ext_tick = 0; slow_int_tick = 0; slow_src_int = 0; sub_div4 = 0;
    pll_locked = 0; mode_wr = 0; mode_sel = 0; stby_wr = 0; stby_sel = 0;
    wake_evt = 0; wake_en = 0; intermittent = 0; cpu_access = 0;
    for (int i = 0; i < 3; i++) step();
    rst_n = 1;
    step(); step();
    gen_on = 1; seen = 0;

    // R1 reset state
    chk("R1 state", stat_state, 0);
    chk("R1 mode", stat_mode, 0);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 pll_en", pll_en, 0);
    chk("R1 settled", settled, 0);

    // R2 main rate
    count_en(20, pn, cn);
    chk("R2 per pulses", pn, 10);
    chk("R2 cpu pulses", cn, 10);

    // R4 R5 pending sub request after reset
    settle_and_switch("R5 R4 power-on");
    chk("R4 src sel", clk_src_sel, 2);
    chk("R4 pll off", pll_en, 0);

    // R4 divider and source sweep
    for (int src = 0; src < 2; src++) begin
      for (int d4 = 0; d4 < 2; d4++) begin
        slow_src_int = src[0]; sub_div4 = d4[0];
        count_en(12, pn, cn);
        count_en(96, pn, cn);
        chk("R4 sub per pulses", pn, (96 / (src == 1 ? 3 : 2)) / (d4 == 1 ? 4 : 2));
        chk("R4 sub cpu pulses", cn, pn);
      end
    end
    slow_src_int = 0; sub_div4 = 0;

    // R12 reserved codes
    write_mode(2'd3);
    chk("R12 reserved mode", stat_mode, 2);
    chk("R12 reserved mode osc", osc_en, 0);
    write_stby(2'd0);
    chk("R12 none standby", stat_state, 0);

    // R3 back to main then PLL with lock wait
    write_mode(2'd0);
    chk("R4 main restores osc", osc_en, 1);
    chk("R4 main status", stat_mode, 0);
    write_mode(2'd1);
    chk("R3 pll_en raised", pll_en, 1);
    chk("R3 mode before lock", stat_mode, 0);
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R3 no switch unlocked", stat_mode, 0);
    end
    pll_locked = 1;
    step();
    chk("R3 switch on lock", stat_mode, 1);
    count_en(10, pn, cn);
    chk("R3 pll per rate", pn, 10);
    chk("R3 pll cpu rate", cn, 10);

    // R11 standby beats mode write; R6 sleep
    mode_wr = 1; mode_sel = 2'd0;
    write_stby(2'd1);
    mode_wr = 0;
    chk("R11 standby wins", stat_state, 1);
    chk("R11 mode write dropped", stat_mode, 1);
    count_en(10, pn, cn);
    chk("R6 sleep cpu off", cn, 0);
    chk("R6 sleep per kept", pn, 10);
    write_mode(2'd0);
    chk("R11 write in sleep ignored", stat_mode, 1);
    write_stby(2'd2);
    chk("R11 standby in sleep ignored", stat_state, 1);
    wake(1'b0);
    chk("R9 disabled wake ignored", stat_state, 1);
    wake(1'b1);
    chk("R9 wake state", stat_state, 0);
    chk("R9 wake mode", stat_mode, 1);
    chk("R9 cpu resumes", cpu_clk_en, 1);

    // R10 intermittent
    intermittent = 1;
    for (int i = 0; i < 18; i++) begin
      cpu_access = (i % 3 == 0);
      step();
      chk("R10 cpu follows access", cpu_clk_en, int'(cpu_access));
      chk("R10 per unaffected", per_clk_en, 1);
    end
    intermittent = 0; cpu_access = 0;

    // R7 watch from main
    write_mode(2'd0);
    pll_locked = 0;
    write_stby(2'd2);
    for (int i = 0; i < 6; i++) begin
      chk("R7 watch state", stat_state, 2);
      chk("R7 cpu off", cpu_clk_en, 0);
      chk("R7 per off", per_clk_en, 0);
      chk("R7 osc off", osc_en, 0);
      chk("R7 pll off", pll_en, 0);
      chk("R7 watch timer on", watch_tmr_en, 1);
      chk("R7 lvd on", lvd_en, 1);
      step();
    end
    wake(1'b1);
    chk("R9 watch wake state", stat_state, 0);
    chk("R9 watch wake mode", stat_mode, 0);
    chk("R9 watch wake osc", osc_en, 1);

    // R8 stop, R5 recount after wake
    write_stby(2'd3);
    m_stop = 1;
    step();
    chk("R5 cleared in stop", settled, 0);
    for (int i = 0; i < 10; i++) begin
      chk("R8 stop state", stat_state, 3);
      chk("R8 osc off", osc_en, 0);
      chk("R8 pll off", pll_en, 0);
      chk("R8 per off", per_clk_en, 0);
      chk("R8 cpu off", cpu_clk_en, 0);
      chk("R8 watch timer off", watch_tmr_en, 0);
      chk("R8 lvd off", lvd_en, 0);
      step();
    end
    wake(1'b1);
    m_stop = 0;
    chk("R9 stop wake state", stat_state, 0);
    chk("R9 stop wake mode", stat_mode, 0);
    settle_and_switch("R5 R4 after stop");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule